// File: doc/BRIEF.md
# Quadrature Decoder with Position Counter

The block reads the two phase-shifted channels of an incremental shaft encoder and samples them on the system clock. Each channel passes through a two-flop synchronizer. A channel's level is accepted only after it has held for three consecutive samples. Every legal change of the two-bit channel state moves an up/down position counter by one, so one encoder cycle gives four counts.

Each counted step produces a one-cycle step pulse. A direction level is registered one cycle ahead of that pulse, so it can be sampled on the pulse's rising edge. When the counter wraps in either direction, a one-cycle wrap pulse coincides with the step pulse. It can clock an external counter, which uses the direction level to extend the position past the internal width. An active-low asynchronous reset clears the counter.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low, `position` is 0, `step_pulse` and `wrap_pulse` are low and `dir_up` is 1, without waiting for a clock edge.
- R2: With the state written {A,B}, the forward sequence 00→01→11→10→00 adds one to `position` for every transition.
- R3: The reverse sequence 00→10→11→01→00 subtracts one from `position` for every transition.
- R4: `dir_up` is 1 after a forward step and 0 after a reverse step. It takes its new value at least one clock before the rising edge of the matching `step_pulse` and keeps it until the next step.
- R5: Each counted transition gives exactly one `step_pulse`, one clock wide, and `position` changes on the same edge that raises it.
- R6: `wrap_pulse` is high for one clock, together with `step_pulse`, exactly when `position` goes from all ones to 0 on a forward step or from 0 to all ones on a reverse step.
- R7: A change of both channels in the same sample is ignored. It gives no `step_pulse` and leaves `position` unchanged.
- R8: A channel level that lasts fewer than three clock cycles is rejected and counts nothing. A level that holds for three or more cycles is accepted.
- R9: The counter width is set by `CNT_W`, with 16 as the default. At `CNT_W`=12 the counter wraps between 0 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_a | input | 1 | Encoder channel A |
| ch_b | input | 1 | Encoder channel B |
| position | output | CNT_W | Position count |
| step_pulse | output | 1 | One-cycle pulse per counted transition |
| dir_up | output | 1 | Direction level: 1 up, 0 down |
| wrap_pulse | output | 1 | One-cycle pulse on counter overflow or underflow |

## Verification
The decoder is driven with two full forward cycles, then a short reverse run. This tells correct 4x decoding apart from 1x or 2x decoding, and it exposes a swapped sense of direction. Steps across zero in both directions separate a correct wrap from a missing or spurious carry pulse, on both the 16-bit and the 12-bit counter. A two-cycle glitch and a simultaneous change of both channels must leave the count unchanged. A monitor confirms that the direction level is stable when the step pulse rises, and that no pulse is wider than one clock.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_a,
  input  logic             ch_b,
  output logic [CNT_W-1:0] position,
  output logic             step_pulse,
  output logic             dir_up,
  output logic             wrap_pulse
);

  logic [1:0] s1, s2, h0, h1, h2, q, q_d;
  logic       pend_up, pend_dn;

  wire [1:0] agree = ~(h0 ^ h1) & ~(h1 ^ h2);
  wire [1:0] chg   = q ^ q_d;
  wire       legal = chg[0] ^ chg[1];
  wire       fwd   = q_d[1] ^ q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0;
      h0 <= '0; h1 <= '0; h2 <= '0;
      q  <= '0; q_d <= '0;
    end else begin
      s1 <= {ch_a, ch_b};
      s2 <= s1;
      h0 <= s2; h1 <= h0; h2 <= h1;
      q  <= (q & ~agree) | (h0 & agree);
      q_d <= q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_up <= 1'b0;
      pend_dn <= 1'b0;
      dir_up  <= 1'b1;
    end else begin
      pend_up <= legal & fwd;
      pend_dn <= legal & ~fwd;
      if (legal) dir_up <= fwd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position   <= '0;
      step_pulse <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      step_pulse <= pend_up | pend_dn;
      wrap_pulse <= (pend_up & (&position)) | (pend_dn & (position == '0));
      if (pend_up)      position <= position + 1'b1;
      else if (pend_dn) position <= position - 1'b1;
    end
  end

  assert_wrap_with_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> step_pulse);

  assert_up_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_up |=> position == $past(position) + 1'b1);

  assert_down_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_dn |=> position == $past(position) - 1'b1);

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |-> $stable(position));

  assert_dir_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_pulse) |-> $stable(dir_up));

  assert_wrap_up_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && dir_up) |-> position == '0);

endmodule

// File: tb/sim_quad_pos_counter.sv
module sim_quad_pos_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_a = 1'b0, ch_b = 1'b0;
  logic [15:0] position;
  logic [11:0] pos12;
  logic step_pulse, dir_up, wrap_pulse;
  logic step12, dir12, wrap12;

  int checks = 0, errors = 0;
  int n_steps = 0, n_wraps = 0, n_wraps12 = 0, n_bad_dir = 0, n_wide = 0;
  logic [1:0] st = 2'b00;
  logic prev_step = 1'b0, prev_wrap = 1'b0, prev_dir = 1'b1;
  int exp_pos = 0;

  always #2 clk = ~clk;

  quad_pos_counter #(.CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b),
    .position(position), .step_pulse(step_pulse), .dir_up(dir_up), .wrap_pulse(wrap_pulse));

  quad_pos_counter #(.CNT_W(12)) u1 (
    .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b),
    .position(pos12), .step_pulse(step12), .dir_up(dir12), .wrap_pulse(wrap12));

  always @(negedge clk) begin
    if (rst_n) begin
      if (step_pulse) n_steps++;
      if (wrap_pulse) n_wraps++;
      if (wrap12) n_wraps12++;
      if (step_pulse && !prev_step && dir_up != prev_dir) n_bad_dir++;
      if ((step_pulse && prev_step) || (wrap_pulse && prev_wrap)) n_wide++;
    end
    prev_step = step_pulse;
    prev_wrap = wrap_pulse;
    prev_dir  = dir_up;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic move(input bit up);
    st = up ? {st[0], ~st[1]} : {~st[0], st[1]};
    {ch_a, ch_b} = st;
    exp_pos += up ? 1 : -1;
    idle(10);
  endtask

  task automatic do_reset();
    {ch_a, ch_b} = 2'b00;
    st = 2'b00;
    exp_pos = 0;
    idle(10);
    @(negedge clk); #1 rst_n = 1'b0;
    #0.5;
    check("R1 position async", position, 0);
    check("R1 step low", step_pulse, 0);
    check("R1 wrap low", wrap_pulse, 0);
    check("R1 dir high", dir_up, 1);
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_forward();
    int s0 = n_steps;
    for (int i = 0; i < 8; i++) move(1'b1);
    idle(5);
    check("R2 position after 8 up", position, 8);
    check("R5 one pulse per step", n_steps - s0, 8);
    check("R4 dir after up", dir_up, 1);
  endtask

  task automatic t_reverse();
    int s0 = n_steps;
    for (int i = 0; i < 3; i++) move(1'b0);
    idle(5);
    check("R3 position after 3 down", position, 5);
    check("R5 pulses on reverse", n_steps - s0, 3);
    check("R4 dir after down", dir_up, 0);
  endtask

  task automatic t_wrap();
    int w0, w1;
    do_reset();
    w0 = n_wraps; w1 = n_wraps12;
    move(1'b0);
    idle(5);
    check("R6 underflow position", position, 16'hFFFF);
    check("R6 underflow wrap pulse", n_wraps - w0, 1);
    check("R9 12-bit underflow", pos12, 12'hFFF);
    check("R9 12-bit wrap pulse", n_wraps12 - w1, 1);
    w0 = n_wraps; w1 = n_wraps12;
    move(1'b1);
    idle(5);
    check("R6 overflow position", position, 0);
    check("R6 overflow wrap pulse", n_wraps - w0, 1);
    check("R9 12-bit overflow", pos12, 0);
    move(1'b1);
    idle(5);
    check("R6 no wrap mid-range", n_wraps - w0, 1);
  endtask

  task automatic t_glitch();
    int s0 = n_steps;
    logic [15:0] p0 = position;
    ch_a = ~st[1];
    idle(2);
    ch_a = st[1];
    idle(15);
    check("R8 short glitch rejected", position, p0);
    check("R8 no pulse on glitch", n_steps - s0, 0);
    ch_a = ~st[1];
    idle(3);
    ch_a = st[1];
    idle(15);
    check("R8 three-cycle level accepted", n_steps - s0, 2);
    check("R8 accept returns position", position, p0);
  endtask

  task automatic t_both();
    int s0 = n_steps;
    logic [15:0] p0 = position;
    st = ~st;
    {ch_a, ch_b} = st;
    idle(15);
    check("R7 both change position", position, p0);
    check("R7 both change no pulse", n_steps - s0, 0);
  endtask

  initial begin
    do_reset();
    t_forward();
    t_reverse();
    t_wrap();
    t_glitch();
    t_both();
    check("R4 dir settled before pulse", n_bad_dir, 0);
    check("R5 pulse width one cycle", n_wide, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule